// File: doc/BRIEF.md
# Quarter-Rate Clock Skew and Duty Calibrator

This block trims a four-phase quarter-rate clock (in-phase, quadrature and their complements) by counting. A free-running clock with no frequency or phase relation to the phases samples them; the synchronised sample bits arrive here together with a valid strobe. Over many such samples, the number of samples in which a phase is high is proportional to its high time. The number of samples in which two phases overlap is proportional to their overlap. The negative quadrature phase is not needed by either measurement, so only three sample bits enter the block.

A calibration is started with a one-cycle pulse. The block first balances the duty cycle and then the I/Q spacing. Each of the two corrections has a 4-bit coarse code and a 6-bit fine code. For each correction the block measures one window of 2^N valid samples and compares the two counts. It then moves one code by one step and repeats. Coarse steps continue until the sign of the count difference reverses, after which fine steps take over. A stage ends when the difference is within a programmable deadband, when the sign reverses during fine stepping, or when the active code cannot move further. A done flag rises after the second stage. Window exponents above 23 are treated as 23, so the 24-bit counters never overflow.

Top module: `skew_cal`

## Requirements
- R1: Synchronous active-high reset sets both coarse codes to 8, both fine codes to 32, and clears busy and done; these values appear at the first clock edge where reset is sampled high.
- R2: A start pulse sampled while busy is low reloads all four codes to 8 and 32, sets busy and clears done at that edge. A start pulse sampled while busy is high has no effect on busy, done or any code.
- R3: A measurement window holds exactly 2^N samples with samp_valid high, where N is win_log2; cycles with samp_valid low are not counted. The first code step of a calibration appears at the edge one cycle after the edge that takes the last sample of the first window.
- R4: In the duty stage the block compares A = number of samples with samp_ip high against B = number of samples with samp_in high. In the quadrature stage it compares A = samples with samp_ip and samp_qp both high against B = samples with samp_qp and samp_in both high.
- R5: With offset A-B, a magnitude at or below deadband counts as balanced and ends the stage without a step. Otherwise a positive offset steps a code down by one and a negative offset steps it up by one.
- R6: In coarse mode the coarse code steps once per window. Coarse mode switches to fine mode, taking a fine step instead of a coarse step in that window, when either of these holds: the offset sign differs from the previous window of the same stage, or the coarse code is already at its limit in the step direction.
- R7: In fine mode the stage ends without a step on a balanced offset, on a sign reversal against the previous window, or when the fine code is at its limit in the step direction; otherwise the fine code takes one step.
- R8: Codes saturate: coarse stays within 0..15 and fine within 0..63, never wrapping, and no code moves by more than one per edge outside a reload.
- R9: The duty stage runs first and the quadrature stage second; when the quadrature stage ends, done rises and busy falls at the same edge, and the codes then hold until the next start or reset.
- R10: The quadrature codes do not change during the duty stage, and the duty codes do not change during the quadrature stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a calibration |
| samp_valid | input | 1 | The sample bits on this cycle are a new sample |
| samp_ip | input | 1 | Sampled in-phase clock |
| samp_qp | input | 1 | Sampled quadrature clock |
| samp_in | input | 1 | Sampled complement of the in-phase clock |
| win_log2 | input | 5 | Window length exponent N (2^N valid samples) |
| deadband | input | 24 | Largest offset magnitude treated as balanced |
| duty_coarse | output | 4 | Duty-cycle corrector coarse code |
| duty_fine | output | 6 | Duty-cycle corrector fine code |
| quad_coarse | output | 4 | Quadrature corrector coarse code |
| quad_fine | output | 6 | Quadrature corrector fine code |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Last calibration has finished |

## Verification
A closed-loop plant in the bench turns the current codes into phase high times, so the sample bits respond to each trim step as a real corrector would. A stride-397 walk over 1024 sample positions with 1024-sample windows gives exact counts. From this pattern the final codes can be predicted: a small duty error with a modest quadrature error shows the coarse-to-fine handover on a sign reversal, and a zero offset ends the quadrature stage in coarse mode. A large duty error with 64-sample windows drives every code into its lower limit, which separates saturation from wrapping and tests the hand-over on a coarse limit. Short windows with no valid gaps pin down the cycle of the first step. Gapped valid strobes, a zero deadband, a start pulse during a run and a reset in mid-run are compared cycle by cycle against the reference model.

// File: rtl/skew_cal_pkg.sv
package skew_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_EVAL = 2'd2
  } cal_state_e;

  typedef enum logic {
    STG_DUTY = 1'b0,
    STG_QUAD = 1'b1
  } cal_stage_e;

  typedef enum logic {
    GR_COARSE = 1'b0,
    GR_FINE   = 1'b1
  } cal_grain_e;

endpackage

// File: rtl/skew_cal_window.sv
module skew_cal_window #(
  parameter int CNT_W = 24,
  parameter int LOG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [LOG_W-1:0] win_log2,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             last
);

  localparam int MAX_LOG = CNT_W - 1;

  logic [LOG_W-1:0] n_eff;
  logic [CNT_W-1:0] target_m1;
  logic [CNT_W-1:0] nsamp_q;
  logic [1:0]       hit;
  logic [CNT_W-1:0] cnt_q [2];

  // the limit keeps a full window of hits inside the counter width
  always_comb begin
    n_eff     = (win_log2 > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : win_log2;
    target_m1 = (CNT_W'(1) << n_eff) - CNT_W'(1);
    last      = en && (nsamp_q == target_m1);
    hit       = {hit_b, hit_a};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      nsamp_q <= '0;
    end else if (en) begin
      nsamp_q <= nsamp_q + 1'b1;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q[k] <= '0;
      end else if (en && hit[k]) begin
        cnt_q[k] <= cnt_q[k] + 1'b1;
      end
    end
  end

  assign cnt_a = cnt_q[0];
  assign cnt_b = cnt_q[1];

endmodule

// File: rtl/skew_cal_trim.sv
module skew_cal_trim #(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         dn,
  output logic [W-1:0] code,
  output logic         at_min,
  output logic         at_max
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] code_q;

  assign at_min = (code_q == '0);
  assign at_max = (code_q == TOP);
  assign code   = code_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      code_q <= INIT;
    end else if (step) begin
      if (dn && !at_min) begin
        code_q <= code_q - 1'b1;
      end else if (!dn && !at_max) begin
        code_q <= code_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/skew_cal_ctrl.sv
module skew_cal_ctrl
  import skew_cal_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             last,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic [CNT_W-1:0] deadband,
  input  logic             crs_min,
  input  logic             crs_max,
  input  logic             fin_min,
  input  logic             fin_max,
  output cal_stage_e       stage,
  output logic             meas,
  output logic             load,
  output logic             crs_step,
  output logic             fin_step,
  output logic             step_dn,
  output logic             busy,
  output logic             done
);

  cal_state_e state_q;
  cal_stage_e stage_q;
  cal_grain_e grain_q;
  logic       prev_neg_q;
  logic       sgn_vld_q;
  logic       busy_q;
  logic       done_q;

  logic signed [CNT_W:0] off;
  logic [CNT_W:0]        mag;
  logic                  neg;
  logic                  bal;
  logic                  flip;
  logic                  crs_lim;
  logic                  fin_lim;
  logic                  stage_end;
  logic                  to_fine;

  // one extra bit so the difference of two full counts cannot overflow
  always_comb begin
    off     = $signed({1'b0, cnt_a}) - $signed({1'b0, cnt_b});
    neg     = off[CNT_W];
    mag     = neg ? (CNT_W+1)'(-off) : (CNT_W+1)'(off);
    bal     = (mag <= {1'b0, deadband});
    flip    = sgn_vld_q && (neg != prev_neg_q);
    step_dn = !neg;
    crs_lim = step_dn ? crs_min : crs_max;
    fin_lim = step_dn ? fin_min : fin_max;

    crs_step  = 1'b0;
    fin_step  = 1'b0;
    stage_end = 1'b0;
    to_fine   = 1'b0;
    if (state_q == ST_EVAL) begin
      if (grain_q == GR_COARSE) begin
        if (bal) begin
          stage_end = 1'b1;
        end else if (flip || crs_lim) begin
          fin_step = 1'b1;
          to_fine  = 1'b1;
        end else begin
          crs_step = 1'b1;
        end
      end else begin
        if (bal || flip || fin_lim) begin
          stage_end = 1'b1;
        end else begin
          fin_step = 1'b1;
        end
      end
    end

    load = (state_q == ST_IDLE) && start;
    meas = (state_q == ST_MEAS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      stage_q    <= STG_DUTY;
      grain_q    <= GR_COARSE;
      prev_neg_q <= 1'b0;
      sgn_vld_q  <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_MEAS;
            stage_q   <= STG_DUTY;
            grain_q   <= GR_COARSE;
            sgn_vld_q <= 1'b0;
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
          end
        end
        ST_MEAS: begin
          if (last) begin
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          prev_neg_q <= neg;
          sgn_vld_q  <= 1'b1;
          if (to_fine) begin
            grain_q <= GR_FINE;
          end
          if (stage_end) begin
            if (stage_q == STG_DUTY) begin
              stage_q   <= STG_QUAD;
              grain_q   <= GR_COARSE;
              sgn_vld_q <= 1'b0;
              state_q   <= ST_MEAS;
            end else begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end
          end else begin
            state_q <= ST_MEAS;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stage = stage_q;
  assign busy  = busy_q;
  assign done  = done_q;

endmodule

// File: rtl/skew_cal.sv
module skew_cal
  import skew_cal_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOG_W = 5,
  parameter int CRS_W = 4,
  parameter int FIN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             samp_valid,
  input  logic             samp_ip,
  input  logic             samp_qp,
  input  logic             samp_in,
  input  logic [LOG_W-1:0] win_log2,
  input  logic [CNT_W-1:0] deadband,
  output logic [CRS_W-1:0] duty_coarse,
  output logic [FIN_W-1:0] duty_fine,
  output logic [CRS_W-1:0] quad_coarse,
  output logic [FIN_W-1:0] quad_fine,
  output logic             busy,
  output logic             done
);

  localparam logic [CRS_W-1:0] CRS_MID = CRS_W'(1) << (CRS_W - 1);
  localparam logic [FIN_W-1:0] FIN_MID = FIN_W'(1) << (FIN_W - 1);
  localparam int               N_CORR  = 2;

  cal_stage_e       stage;
  logic             meas;
  logic             load;
  logic             crs_step;
  logic             fin_step;
  logic             step_dn;
  logic             hit_a;
  logic             hit_b;
  logic             last;
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cnt_b;

  logic [CRS_W-1:0] crs_code [N_CORR];
  logic [FIN_W-1:0] fin_code [N_CORR];
  logic [N_CORR-1:0] crs_min_v;
  logic [N_CORR-1:0] crs_max_v;
  logic [N_CORR-1:0] fin_min_v;
  logic [N_CORR-1:0] fin_max_v;
  logic             crs_min;
  logic             crs_max;
  logic             fin_min;
  logic             fin_max;

  // duty: each phase alone; quadrature: overlaps sharing the Q phase
  always_comb begin
    if (stage == STG_DUTY) begin
      hit_a = samp_ip;
      hit_b = samp_in;
    end else begin
      hit_a = samp_ip & samp_qp;
      hit_b = samp_qp & samp_in;
    end
    crs_min = (stage == STG_QUAD) ? crs_min_v[1] : crs_min_v[0];
    crs_max = (stage == STG_QUAD) ? crs_max_v[1] : crs_max_v[0];
    fin_min = (stage == STG_QUAD) ? fin_min_v[1] : fin_min_v[0];
    fin_max = (stage == STG_QUAD) ? fin_max_v[1] : fin_max_v[0];
  end

  skew_cal_window #(
    .CNT_W (CNT_W),
    .LOG_W (LOG_W)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .clr      (!meas),
    .en       (meas && samp_valid),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .win_log2 (win_log2),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .last     (last)
  );

  skew_cal_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .last     (last),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .deadband (deadband),
    .crs_min  (crs_min),
    .crs_max  (crs_max),
    .fin_min  (fin_min),
    .fin_max  (fin_max),
    .stage    (stage),
    .meas     (meas),
    .load     (load),
    .crs_step (crs_step),
    .fin_step (fin_step),
    .step_dn  (step_dn),
    .busy     (busy),
    .done     (done)
  );

  for (genvar g = 0; g < N_CORR; g++) begin : g_corr
    logic sel;
    assign sel = (stage == ((g == 0) ? STG_DUTY : STG_QUAD));

    skew_cal_trim #(
      .W    (CRS_W),
      .INIT (CRS_MID)
    ) u_crs (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step   (crs_step && sel),
      .dn     (step_dn),
      .code   (crs_code[g]),
      .at_min (crs_min_v[g]),
      .at_max (crs_max_v[g])
    );

    skew_cal_trim #(
      .W    (FIN_W),
      .INIT (FIN_MID)
    ) u_fin (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step   (fin_step && sel),
      .dn     (step_dn),
      .code   (fin_code[g]),
      .at_min (fin_min_v[g]),
      .at_max (fin_max_v[g])
    );
  end

  assign duty_coarse = crs_code[0];
  assign duty_fine   = fin_code[0];
  assign quad_coarse = crs_code[1];
  assign quad_fine   = fin_code[1];

endmodule

// File: rtl/skew_cal_chk.sv
module skew_cal_chk #(
  parameter int CRS_W = 4,
  parameter int FIN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             stage,
  input logic [CRS_W-1:0] duty_coarse,
  input logic [FIN_W-1:0] duty_fine,
  input logic [CRS_W-1:0] quad_coarse,
  input logic [FIN_W-1:0] quad_fine
);

  localparam logic [CRS_W-1:0] CRS_MID = CRS_W'(1) << (CRS_W - 1);
  localparam logic [FIN_W-1:0] FIN_MID = FIN_W'(1) << (FIN_W - 1);

  p_reset_mid_r1: assert property (@(posedge clk)
    $past(rst) |-> (duty_coarse == CRS_MID && quad_coarse == CRS_MID &&
                    duty_fine == FIN_MID && quad_fine == FIN_MID && !busy && !done));

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done && duty_coarse == CRS_MID && duty_fine == FIN_MID &&
                          quad_coarse == CRS_MID && quad_fine == FIN_MID));

  p_duty_crs_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |->
      ({1'b0, duty_coarse} == {1'b0, $past(duty_coarse)} ||
       {1'b0, duty_coarse} == {1'b0, $past(duty_coarse)} + 1'b1 ||
       {1'b0, $past(duty_coarse)} == {1'b0, duty_coarse} + 1'b1));

  p_duty_fin_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |->
      ({1'b0, duty_fine} == {1'b0, $past(duty_fine)} ||
       {1'b0, duty_fine} == {1'b0, $past(duty_fine)} + 1'b1 ||
       {1'b0, $past(duty_fine)} == {1'b0, duty_fine} + 1'b1));

  p_quad_crs_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |->
      ({1'b0, quad_coarse} == {1'b0, $past(quad_coarse)} ||
       {1'b0, quad_coarse} == {1'b0, $past(quad_coarse)} + 1'b1 ||
       {1'b0, $past(quad_coarse)} == {1'b0, quad_coarse} + 1'b1));

  p_quad_fin_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |->
      ({1'b0, quad_fine} == {1'b0, $past(quad_fine)} ||
       {1'b0, quad_fine} == {1'b0, $past(quad_fine)} + 1'b1 ||
       {1'b0, $past(quad_fine)} == {1'b0, quad_fine} + 1'b1));

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && !$past(start)) |->
      ($stable(duty_coarse) && $stable(duty_fine) && $stable(quad_coarse) && $stable(quad_fine)));

  p_quad_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && !$past(stage)) |->
      ($stable(quad_coarse) && $stable(quad_fine)));

  p_duty_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && $past(stage)) |->
      ($stable(duty_coarse) && $stable(duty_fine)));

endmodule

bind skew_cal skew_cal_chk #(
  .CRS_W (CRS_W),
  .FIN_W (FIN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .stage       (stage),
  .duty_coarse (duty_coarse),
  .duty_fine   (duty_fine),
  .quad_coarse (quad_coarse),
  .quad_fine   (quad_fine)
);

// File: tb/skew_cal_tb.sv
`timescale 1ns/1ps
module skew_cal_tb;

  localparam int WDOG = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ip = 1'b0;
  logic        samp_qp = 1'b0;
  logic        samp_in = 1'b0;
  logic [4:0]  win_log2 = 5'd10;
  logic [23:0] deadband = 24'd4;
  logic [3:0]  duty_coarse;
  logic [5:0]  duty_fine;
  logic [3:0]  quad_coarse;
  logic [5:0]  quad_fine;
  logic        busy;
  logic        done;

  always #2 clk = ~clk;

  skew_cal u_dut (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .samp_valid  (samp_valid),
    .samp_ip     (samp_ip),
    .samp_qp     (samp_qp),
    .samp_in     (samp_in),
    .win_log2    (win_log2),
    .deadband    (deadband),
    .duty_coarse (duty_coarse),
    .duty_fine   (duty_fine),
    .quad_coarse (quad_coarse),
    .quad_fine   (quad_fine),
    .busy        (busy),
    .done        (done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_on = 0;

  // plant: error terms and sample walk
  int ed = 0;
  int eq = 0;
  bit gap_en = 1;
  int pos = 0;

  always @(negedge clk) begin
    int e;
    int q;
    #1;
    if (samp_valid) pos = (pos + 397) % 1024;
    samp_valid = gap_en ? ((cyc % 5) != 2) : 1'b1;
    e = ed + 16 * (int'(duty_coarse) - 8) + (int'(duty_fine) - 32);
    q = eq - 16 * (int'(quad_coarse) - 8) - (int'(quad_fine) - 32);
    samp_ip = (pos < 512 + e);
    samp_in = !(pos < 512 + e);
    samp_qp = (pos >= 256 + q) && (pos < 768 + q);
  end

  // reference model
  int m_st, m_stage, m_grain, m_n, m_a, m_b, m_pn, m_sv, m_busy, m_done;
  int m_code [4];

  function automatic int lim_step(int v, bit dn, int maxv);
    if (dn) return (v > 0) ? v - 1 : v;
    return (v < maxv) ? v + 1 : v;
  endfunction

  always @(posedge clk) begin
    int off, mag, ci, fi;
    bit neg, bal, flip, endst, dn, ha, hb;
    if (rst) begin
      m_st = 0; m_stage = 0; m_grain = 0; m_n = 0; m_a = 0; m_b = 0;
      m_pn = 0; m_sv = 0; m_busy = 0; m_done = 0;
      m_code[0] = 8; m_code[1] = 32; m_code[2] = 8; m_code[3] = 32;
    end else begin
      case (m_st)
        0: if (start) begin
          m_code[0] = 8; m_code[1] = 32; m_code[2] = 8; m_code[3] = 32;
          m_st = 1; m_stage = 0; m_grain = 0; m_sv = 0; m_busy = 1; m_done = 0;
          m_a = 0; m_b = 0; m_n = 0;
        end
        1: if (samp_valid) begin
          ha = (m_stage == 0) ? samp_ip : (samp_ip && samp_qp);
          hb = (m_stage == 0) ? samp_in : (samp_qp && samp_in);
          m_a += int'(ha);
          m_b += int'(hb);
          m_n++;
          if (m_n == (1 << win_log2)) m_st = 2;
        end
        default: begin
          off = m_a - m_b;
          neg = (off < 0);
          mag = neg ? -off : off;
          bal = (mag <= int'(deadband));
          flip = m_sv && (int'(neg) != m_pn);
          dn = !neg;
          ci = m_stage * 2;
          fi = ci + 1;
          endst = 0;
          if (m_grain == 0) begin
            if (bal) endst = 1;
            else if (flip || (dn ? m_code[ci] == 0 : m_code[ci] == 15)) begin
              m_code[fi] = lim_step(m_code[fi], dn, 63);
              m_grain = 1;
            end else m_code[ci] = lim_step(m_code[ci], dn, 15);
          end else begin
            if (bal || flip || (dn ? m_code[fi] == 0 : m_code[fi] == 63)) endst = 1;
            else m_code[fi] = lim_step(m_code[fi], dn, 63);
          end
          m_pn = int'(neg); m_sv = 1; m_a = 0; m_b = 0; m_n = 0;
          if (endst) begin
            if (m_stage == 0) begin
              m_stage = 1; m_grain = 0; m_sv = 0; m_st = 1;
            end else begin
              m_st = 0; m_busy = 0; m_done = 1;
            end
          end else m_st = 1;
        end
      endcase
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    cmp_on = 1;
    if (cyc == WDOG) begin
      n_fail++;
      $display("FAIL R9 watchdog: done=%0d expected 1", done);
      summary();
      $finish;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (int'(busy) != m_busy || int'(done) != m_done) begin
        n_fail++;
        $display("FAIL R9 status: busy=%0d done=%0d expected busy=%0d done=%0d",
                 busy, done, m_busy, m_done);
      end else if (int'(duty_coarse) != m_code[0] || int'(duty_fine) != m_code[1]) begin
        n_fail++;
        $display("FAIL R5 duty codes: %0d/%0d expected %0d/%0d",
                 duty_coarse, duty_fine, m_code[0], m_code[1]);
      end else if (int'(quad_coarse) != m_code[2] || int'(quad_fine) != m_code[3]) begin
        n_fail++;
        $display("FAIL R10 quad codes: %0d/%0d expected %0d/%0d",
                 quad_coarse, quad_fine, m_code[2], m_code[3]);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done && cyc < WDOG - 2) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 duty_coarse", duty_coarse, 8);
    chk("R1 duty_fine", duty_fine, 32);
    chk("R1 quad_coarse", quad_coarse, 8);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);

    // run 1: small duty error, modest quadrature error, exact 1024-sample windows
    ed = 70; eq = -50; win_log2 = 5'd10; deadband = 24'd4; gap_en = 1;
    pulse_start();
    chk("R2 busy after start", busy, 1);
    chk("R2 done after start", done, 0);
    wait_done();
    chk("R6 duty coarse after sign reversal", duty_coarse, 3);
    chk("R7 duty fine at balance", duty_fine, 40);
    chk("R4 quad coarse at balance", quad_coarse, 5);
    chk("R5 quad fine untouched when balanced in coarse", quad_fine, 32);
    chk("R9 done", done, 1);
    chk("R9 busy", busy, 0);
    repeat (20) tick();
    chk("R9 hold duty fine", duty_fine, 40);
    chk("R9 hold quad coarse", quad_coarse, 5);

    // run 2: large duty error drives every code to its floor
    ed = 400; eq = 0; win_log2 = 5'd6; deadband = 24'd2;
    pulse_start();
    chk("R2 reload duty coarse", duty_coarse, 8);
    chk("R2 reload duty fine", duty_fine, 32);
    repeat (100) tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R2 start while busy ignored", busy, 1);
    wait_done();
    chk("R8 duty coarse saturates", duty_coarse, 0);
    chk("R8 duty fine saturates", duty_fine, 0);
    chk("R8 quad coarse saturates", quad_coarse, 0);
    chk("R8 quad fine saturates", quad_fine, 0);

    // run 3: window timing with 4-sample windows and no gaps
    ed = 500; eq = 0; win_log2 = 5'd2; deadband = 24'd0; gap_en = 0;
    pulse_start();
    repeat (4) tick();
    chk("R3 no step before window evaluation", duty_coarse, 8);
    tick();
    chk("R3 first step one cycle after last sample", duty_coarse, 7);
    wait_done();
    chk("R9 run 3 done", done, 1);

    // run 4: zero deadband, negative duty error, gapped strobe
    ed = -33; eq = 25; win_log2 = 5'd4; deadband = 24'd0; gap_en = 1;
    pulse_start();
    wait_done();
    chk("R9 run 4 done", done, 1);

    // run 5: reset in the middle of a calibration
    ed = 90; eq = 40; win_log2 = 5'd5;
    pulse_start();
    repeat (150) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid-run reset duty coarse", duty_coarse, 8);
    chk("R1 mid-run reset quad fine", quad_fine, 32);
    chk("R1 mid-run reset busy", busy, 0);
    repeat (4) tick();

    summary();
    $finish;
  end

endmodule